// File: doc/BRIEF.md
# Configuration Port Access Sequencer

This block runs one access session against an on-chip configuration port. The port has a 32-bit data bus in each direction, an active-low enable, an active-low write select (high selects a read) and a BUSY input. A host pulses `start_i`. The sequencer then synchronises the port and reads back the device identifier and the status register. It compares the identifier with the expected code under a mask. If the compare passes, it streams configuration words taken from a FIFO-style input. Every session, whether it passes or fails, ends with a desynchronise command.

The port takes one word per accepted cycle, with no wait states, and long write bursts hold the strobes active. A word is accepted on a clock edge where enable is low and BUSY is low. While BUSY is high, the word on the bus and both strobes are held unchanged. The direction only ever changes after enable has been high for at least one cycle. A per-word BUSY watchdog drops a stuck transfer and steers the session to its closing command. The result is reported with a one-cycle `done_o` pulse and a `pass_o` level.

Top module: `cfg_port_sequencer`

## Requirements
- R1: Outside a session `port_en_n_o` is 1. A write is presented as `port_en_n_o`=0 with `port_wr_n_o`=0, and a read as `port_en_n_o`=0 with `port_wr_n_o`=1. A word counts as transferred on a rising edge where `port_en_n_o`=0 and `port_busy_i`=0.
- R2: A session opens with three written words in this order: 0xFFFFFFFF, 0xAA995566, 0x20000000.
- R3: Next comes the identifier readback: write 0x28018001, write 0x20000000, then one read. After it comes the status readback: write 0x2800E001, write 0x20000000, then one read. Read data is sampled from `port_din_i` on the edge that transfers the read.
- R4: `port_wr_n_o` never changes while `port_en_n_o` stays 0 across consecutive cycles. Every change of direction is preceded by at least one cycle with `port_en_n_o`=1.
- R5: While a presented word sees `port_busy_i`=1, `port_dout_o`, `port_wr_n_o` and the low enable stay unchanged on the next cycle, unless the watchdog expires.
- R6: The identifier passes when ((id ^ ID_EXPECT) & ID_MASK) == 0. The defaults are 0x0127E093 and 0x0FFFFFFF, so the top nibble is ignored.
- R7: Only after a passing identifier and a completed status read are FIFO words written, in order, from `fifo_data_i`. `fifo_ready_o` is 1 for exactly the cycle in which a word is taken. Streaming stops after the transfer of the word flagged by `fifo_last_i`. On a failing identifier, no word is taken.
- R8: Every session closes with four written words in this order: 0x30008001, 0x0000000D, 0x20000000, 0x20000000.
- R9: After BUSY_LIMIT consecutive busy cycles on one presented word, that word is abandoned, enable goes high and the session fails. A timeout before the closing words still issues them. A timeout during the closing words ends the session at once.
- R10: `done_o` is a one-cycle pulse at the end of a session. `pass_o` is 1 only if no check failed, and it holds until the next start. A `start_i` during a session is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a session when idle |
| fifo_data_i | input | 32 | Configuration word at the FIFO head |
| fifo_valid_i | input | 1 | FIFO head holds a word |
| fifo_last_i | input | 1 | FIFO head word is the last of the burst |
| fifo_ready_o | output | 1 | Head word taken this cycle |
| port_en_n_o | output | 1 | Port enable, active low |
| port_wr_n_o | output | 1 | Port write select, low = write, high = read |
| port_dout_o | output | 32 | Word written to the port |
| port_din_i | input | 32 | Word read from the port |
| port_busy_i | input | 1 | Port cannot take the current word |
| done_o | output | 1 | Session finished (one-cycle pulse) |
| pass_o | output | 1 | Last session succeeded |

## Verification
A wrong step counter shows at the ports as a transferred word out of sequence. The bench logs every transfer, and the mismatch appears as soon as the final log is compared. A wrong hold or direction decision shows within one cycle as a changed bus word under BUSY, or as a select change while enable stays low. The negative-edge monitor catches it on that cycle. A wrong failure flag shows up as FIFO pops or a wrong `pass_o` at the `done_o` pulse. A miscounting watchdog shows as a stuck-busy interval that differs from BUSY_LIMIT.

// File: rtl/cps_pkg.sv
package cps_pkg;
    localparam int DATA_W = 32;
    localparam int STEP_W = 5;

    typedef enum logic [2:0] {
        K_WR, K_GAP, K_RD_ID, K_RD_STAT, K_STREAM, K_END
    } item_kind_e;

    localparam logic [STEP_W-1:0] STEP_STREAM = 5'd13;
    localparam logic [STEP_W-1:0] STEP_CLOSE  = 5'd14;
    localparam logic [STEP_W-1:0] STEP_END    = 5'd18;

    localparam logic [DATA_W-1:0] W_DUMMY   = 32'hFFFF_FFFF;
    localparam logic [DATA_W-1:0] W_SYNC    = 32'hAA99_5566;
    localparam logic [DATA_W-1:0] W_NOP     = 32'h2000_0000;
    localparam logic [DATA_W-1:0] W_RD_ID   = 32'h2801_8001;
    localparam logic [DATA_W-1:0] W_RD_STAT = 32'h2800_E001;
    localparam logic [DATA_W-1:0] W_WR_CMD  = 32'h3000_8001;
    localparam logic [DATA_W-1:0] W_DESYNC  = 32'h0000_000D;

    function automatic item_kind_e step_kind(input logic [STEP_W-1:0] s);
        case (s)
            5'd5, 5'd7, 5'd10, 5'd12: step_kind = K_GAP;
            5'd6:                     step_kind = K_RD_ID;
            5'd11:                    step_kind = K_RD_STAT;
            STEP_STREAM:              step_kind = K_STREAM;
            STEP_END:                 step_kind = K_END;
            default:                  step_kind = (s > STEP_END) ? K_END : K_WR;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] step_word(input logic [STEP_W-1:0] s);
        case (s)
            5'd0:    step_word = W_DUMMY;
            5'd1:    step_word = W_SYNC;
            5'd3:    step_word = W_RD_ID;
            5'd8:    step_word = W_RD_STAT;
            5'd14:   step_word = W_WR_CMD;
            5'd15:   step_word = W_DESYNC;
            default: step_word = W_NOP;
        endcase
    endfunction
endpackage

// File: rtl/cps_id_match.sv
module cps_id_match #(
    parameter logic [31:0] ID_EXPECT = 32'h0127_E093,
    parameter logic [31:0] ID_MASK   = 32'h0FFF_FFFF
) (
    input  logic [31:0] word_i,
    output logic        match_o
);
    // Masked-out bits (revision nibble by default) never affect the result.
    assign match_o = ((word_i ^ ID_EXPECT) & ID_MASK) == 32'h0;
endmodule

// File: rtl/cps_busy_watch.sv
module cps_busy_watch #(
    parameter int BUSY_LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stall_i,
    output logic expired_o
);
    localparam int CNT_W = $clog2(BUSY_LIMIT + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } watch_t;

    watch_t w_d, w_q;

    always_comb begin
        w_d = w_q;
        w_d.cnt = stall_i ? w_q.cnt + CNT_W'(1) : '0;
    end

    assign expired_o = stall_i && (w_q.cnt == CNT_W'(BUSY_LIMIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end
endmodule

// File: rtl/cfg_port_sequencer.sv
module cfg_port_sequencer
    import cps_pkg::*;
#(
    parameter logic [31:0] ID_EXPECT  = 32'h0127_E093,
    parameter logic [31:0] ID_MASK    = 32'h0FFF_FFFF,
    parameter int          BUSY_LIMIT = 1024
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic [31:0] fifo_data_i,
    input  logic        fifo_valid_i,
    input  logic        fifo_last_i,
    output logic        fifo_ready_o,
    output logic        port_en_n_o,
    output logic        port_wr_n_o,
    output logic [31:0] port_dout_o,
    input  logic [31:0] port_din_i,
    input  logic        port_busy_i,
    output logic        done_o,
    output logic        pass_o
);
    typedef struct packed {
        logic              run;
        logic [STEP_W-1:0] step;
        logic              en_n;
        logic              wr_n;
        logic [DATA_W-1:0] dout;
        logic              last;
        logic              fail;
        logic              done;
        logic              pass;
    } seq_t;

    seq_t q, d;
    logic id_ok, tmo_expired, stall;
    logic load_req, pop;
    logic [STEP_W-1:0] load_step;
    item_kind_e cur_kind, load_kind;

    assign stall = q.run && !q.en_n && port_busy_i;

    cps_id_match #(.ID_EXPECT(ID_EXPECT), .ID_MASK(ID_MASK)) u_id (
        .word_i (port_din_i),
        .match_o(id_ok)
    );

    cps_busy_watch #(.BUSY_LIMIT(BUSY_LIMIT)) u_watch (
        .clk      (clk),
        .rst_n    (rst_n),
        .stall_i  (stall),
        .expired_o(tmo_expired)
    );

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        pop       = 1'b0;
        load_req  = 1'b0;
        load_step = q.step;
        cur_kind  = step_kind(q.step);
        if (!q.run) begin
            if (start_i) begin
                d.run  = 1'b1;
                d.step = '0;
                d.fail = 1'b0;
                d.pass = 1'b0;
            end
        end else if (!q.en_n) begin
            if (port_busy_i) begin
                if (tmo_expired) begin
                    d.en_n = 1'b1;
                    d.fail = 1'b1;
                    d.step = (q.step >= STEP_CLOSE) ? STEP_END : STEP_CLOSE;
                end
            end else begin
                if (cur_kind == K_RD_ID && !id_ok) d.fail = 1'b1;
                load_req  = 1'b1;
                load_step = (q.step == STEP_STREAM && !q.last) ? q.step : q.step + 1'b1;
            end
        end else begin
            load_req = 1'b1;
        end

        load_kind = step_kind(load_step);
        if (load_req) begin
            d.step = load_step;
            case (load_kind)
                K_WR: begin
                    d.en_n = 1'b0;
                    d.wr_n = 1'b0;
                    d.dout = step_word(load_step);
                end
                K_RD_ID, K_RD_STAT: begin
                    d.en_n = 1'b0;
                    d.wr_n = 1'b1;
                end
                K_GAP: begin
                    d.en_n = 1'b1;
                    d.step = load_step + 1'b1;
                end
                K_STREAM: begin
                    if (d.fail) begin
                        d.en_n = 1'b1;
                        d.step = STEP_CLOSE;
                    end else if (fifo_valid_i) begin
                        d.en_n = 1'b0;
                        d.wr_n = 1'b0;
                        d.dout = fifo_data_i;
                        d.last = fifo_last_i;
                        pop    = 1'b1;
                    end else begin
                        d.en_n = 1'b1;
                    end
                end
                default: begin
                    d.en_n = 1'b1;
                    d.run  = 1'b0;
                    d.done = 1'b1;
                    d.pass = !d.fail;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.en_n <= 1'b1;
            q.wr_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign fifo_ready_o = pop;
    assign port_en_n_o  = q.en_n;
    assign port_wr_n_o  = q.wr_n;
    assign port_dout_o  = q.dout;
    assign done_o       = q.done;
    assign pass_o       = q.pass;

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !q.run |-> port_en_n_o);

    assert_select_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en_n_o |=> (port_en_n_o || $stable(port_wr_n_o)));

    assert_hold_under_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!port_en_n_o && port_busy_i && !tmo_expired) |=>
        (!port_en_n_o && $stable(port_dout_o) && $stable(port_wr_n_o)));

    assert_pop_lands_on_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_ready_o |=> (!port_en_n_o && !port_wr_n_o && port_dout_o == $past(fifo_data_i)));

    assert_timeout_releases_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_expired |=> port_en_n_o);

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
endmodule

// File: tb/cfg_port_sequencer_bench.sv
module cfg_port_sequencer_bench;
    localparam int LIMIT = 8;
    localparam logic [31:0] ID_GOOD = 32'h0127_E093;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [31:0] fifo_data;
    logic fifo_valid, fifo_last, fifo_ready;
    logic en_n, wr_n;
    logic [31:0] dout, din;
    logic busy = 1'b0;
    logic done, pass;

    always #5 clk = ~clk;

    cfg_port_sequencer #(.BUSY_LIMIT(LIMIT)) u_cfg_port_sequencer (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .fifo_data_i(fifo_data), .fifo_valid_i(fifo_valid), .fifo_last_i(fifo_last),
        .fifo_ready_o(fifo_ready), .port_en_n_o(en_n), .port_wr_n_o(wr_n),
        .port_dout_o(dout), .port_din_i(din), .port_busy_i(busy),
        .done_o(done), .pass_o(pass)
    );

    int vectors = 0;
    int fails = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // FIFO model
    logic [31:0] fmem [8];
    int fifo_n = 0;
    int fptr = 0;
    logic fifo_hold = 1'b0;
    assign fifo_valid = (fptr < fifo_n) && !fifo_hold;
    assign fifo_data  = fmem[fptr[2:0]];
    assign fifo_last  = (fptr == fifo_n - 1);
    always @(posedge clk) if (fifo_ready) fptr <= fptr + 1;

    // Port model
    logic [31:0] id_val = ID_GOOD;
    logic [31:0] last_hdr = 32'h0;
    assign din = (last_hdr == 32'h2801_8001) ? id_val : 32'h0000_1234;

    logic [31:0] log_d [64];
    bit          log_r [64];
    int log_n = 0;
    logic [31:0] exp_d [64];
    bit          exp_r [64];
    int exp_n = 0;

    bit rand_busy = 0, stall_en = 0, busy_stuck = 0;
    int stuck_cnt = 0, done_cnt = 0, rand_run = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic prev_en = 1'b1, prev_wr = 1'b1, prev_busy = 1'b0;
    logic [31:0] prev_dout = 32'h0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!prev_en && !en_n)
                check(wr_n == prev_wr, "R4 select changed with enable low", {31'h0, wr_n}, {31'h0, prev_wr});
            if (!prev_en && prev_busy && !en_n)
                check(dout == prev_dout && wr_n == prev_wr, "R5 word not held under busy", dout, prev_dout);
            if (busy_stuck && !prev_en && en_n) busy_stuck = 0;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            busy = busy_stuck || (rand_busy && lfsr[1:0] == 2'b00 && rand_run < 3);
            rand_run = (busy && !busy_stuck) ? rand_run + 1 : 0;
            if (busy_stuck && !en_n && busy) stuck_cnt++;
            if (!en_n && !busy && log_n < 64) begin
                log_d[log_n] = wr_n ? 32'h0 : dout;
                log_r[log_n] = wr_n;
                log_n++;
                if (!wr_n && (dout == 32'h2801_8001 || dout == 32'h2800_E001)) last_hdr = dout;
            end
            fifo_hold = stall_en && lfsr[3:2] == 2'b00;
            if (done) done_cnt++;
            prev_en = en_n; prev_wr = wr_n; prev_busy = busy; prev_dout = dout;
        end
    end

    function automatic void push(input bit rd, input logic [31:0] w);
        exp_r[exp_n] = rd; exp_d[exp_n] = w; exp_n++;
    endfunction

    task automatic expect_open();
        push(0, 32'hFFFF_FFFF); push(0, 32'hAA99_5566); push(0, 32'h2000_0000);
        push(0, 32'h2801_8001); push(0, 32'h2000_0000); push(1, 32'h0);
        push(0, 32'h2800_E001); push(0, 32'h2000_0000); push(1, 32'h0);
    endtask

    task automatic expect_close();
        push(0, 32'h3000_8001); push(0, 32'h0000_000D);
        push(0, 32'h2000_0000); push(0, 32'h2000_0000);
    endtask

    task automatic prep(input int nwords, input logic [31:0] id);
        @(negedge clk); #2;
        log_n = 0; exp_n = 0; done_cnt = 0; fptr = 0; fifo_n = nwords; id_val = id;
        for (int i = 0; i < nwords; i++) fmem[i] = 32'hC0DE_0000 + i * 32'h111;
    endtask

    task automatic kick_and_wait(input int extra_start_at);
        @(negedge clk); #2; start = 1'b1;
        @(negedge clk); #2; start = 1'b0;
        for (int i = 0; i < 2000 && !done; i++) begin
            @(negedge clk);
            if (i == extra_start_at) begin #2; start = 1'b1; @(negedge clk); #2; start = 1'b0; end
        end
    endtask

    task automatic compare_log(input string req);
        check(log_n == exp_n, {req, " transfer count"}, log_n, exp_n);
        for (int i = 0; i < exp_n && i < log_n; i++)
            check(log_r[i] == exp_r[i] && log_d[i] == exp_d[i], req, log_d[i], exp_d[i]);
    endtask

    task automatic t_reset();
        check(en_n == 1'b1, "R1 enable idle high after reset", {31'h0, en_n}, 32'h1);
        check(done == 1'b0 && pass == 1'b0, "R10 status clear after reset", {30'h0, done, pass}, 32'h0);
        check(fifo_ready == 1'b0, "R7 no pop at reset", {31'h0, fifo_ready}, 32'h0);
    endtask

    task automatic t_clean_pass();
        prep(4, ID_GOOD);
        rand_busy = 0; stall_en = 0;
        expect_open();
        for (int i = 0; i < 4; i++) push(0, 32'hC0DE_0000 + i * 32'h111);
        expect_close();
        kick_and_wait(12);
        check(done == 1'b1, "R10 done pulse seen", {31'h0, done}, 32'h1);
        check(pass == 1'b1, "R6 exact id passes", {31'h0, pass}, 32'h1);
        compare_log("R2 R3 R7 R8 clean session");
        repeat (3) @(negedge clk);
        check(pass == 1'b1 && done_cnt == 1, "R10 pass held, start ignored mid-session", done_cnt, 32'h1);
        check(en_n == 1'b1, "R1 idle after session", {31'h0, en_n}, 32'h1);
    endtask

    task automatic t_busy_revision();
        prep(6, 32'h1127_E093);
        rand_busy = 1; stall_en = 1;
        expect_open();
        for (int i = 0; i < 6; i++) push(0, 32'hC0DE_0000 + i * 32'h111);
        expect_close();
        kick_and_wait(-1);
        rand_busy = 0; stall_en = 0;
        check(pass == 1'b1, "R6 revision nibble masked", {31'h0, pass}, 32'h1);
        compare_log("R5 R7 session under busy and fifo stalls");
        check(fptr == 6, "R7 all fifo words taken", fptr, 32'd6);
    endtask

    task automatic t_bad_id();
        prep(3, 32'h0127_E094);
        expect_open();
        expect_close();
        kick_and_wait(-1);
        check(pass == 1'b0, "R6 wrong id fails", {31'h0, pass}, 32'h0);
        compare_log("R7 R8 no stream after failed id");
        check(fptr == 0, "R7 no fifo pop on failed id", fptr, 32'h0);
    endtask

    task automatic t_timeout();
        prep(2, ID_GOOD);
        stuck_cnt = 0;
        @(negedge clk); #2; busy_stuck = 1;
        expect_close();
        kick_and_wait(-1);
        check(pass == 1'b0, "R9 timeout fails session", {31'h0, pass}, 32'h0);
        check(stuck_cnt == LIMIT, "R9 busy cycles before abandon", stuck_cnt, LIMIT);
        compare_log("R9 R8 close still issued after timeout");
        check(fptr == 0, "R9 no fifo pop after timeout", fptr, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        #2 rst_n = 1'b1;
        t_clean_pass();
        t_busy_revision();
        t_bad_id();
        t_timeout();
        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule